// File: doc/BRIEF.md
# Infrared Mark/Space Symbol Player

The block turns a queue of timed symbols into an infrared output waveform. Software pushes 32-bit symbol words into a 128-deep queue through a small register port. Each word sets a duration, the unit that duration is counted in, and whether the output carries the carrier for that time (a mark) or stays low (a space). The player pops words in the order they were written and counts each one down. While a mark is playing, it passes the externally generated carrier onto the output pin.

Long transmissions are streamed. Software sets a fill threshold, and a pending flag asks for more words once the queue has drained to that level. When the queue runs dry the output rests low and the player waits for more words. Clearing the run bit drops everything queued and stops the waveform at once.

Register offsets: 0x0 control (bit 0 run), 0x4 status (read-only: bits 7:0 fill level, bit 8 busy), 0x8 queue push (write-only), 0xC refill control (bits 6:0 threshold, bit 8 interrupt enable, bit 16 pending, bit 17 overflow). Reads return the addressed register one cycle after `bus_addr` is presented.

Top module: `irseq_top`

## Requirements
- R1: A write to offset 0x8 adds a word to the queue only when bit 16 of the written data is 1. A write with bit 16 at 0 leaves the fill level unchanged.
- R2: A word with bit 12 = 1 is a mark, and the output follows `carrier_in` (one register of delay) for its duration. A word with bit 12 = 0 is a space, and the output stays 0 for its duration even while the carrier toggles.
- R3: Bits 11:10 choose the unit: 0 = 1 µs, 1 = 10 µs, 2 = 100 µs, where 1 µs is `CLK_PER_US` clock cycles. Bits 9:0 hold the duration minus one. A symbol therefore lasts (bits 9:0 + 1) × unit cycles, counted exactly from the cycle it is popped, up to 1024 units.
- R4: Unit code 3 counts rising edges of `carrier_in`. The symbol ends on the (bits 9:0 + 1)-th rising edge seen after it starts.
- R5: Symbols play in write order, back to back, with no idle cycle between two queued symbols.
- R6: When the last queued symbol ends, the output returns to 0 and busy clears. A word written later starts playing without any further action.
- R7: A push into a full queue is dropped and sets the overflow flag (0xC bit 17). The flag stays set until software writes 0xC with bit 17 = 0. The fill level never exceeds the depth.
- R8: The pending flag (0xC bit 16) sets while the interrupt enable (0xC bit 8) is 1 and the fill level is at or below the threshold. Writing 0xC with bit 16 = 0 clears the flag; writing bit 16 = 1 leaves it as it is.
- R9: `irq` is high exactly when the pending flag and the interrupt enable are both 1.
- R10: Words pushed while the run bit is 0 are held and start playing once it is set. Writing 0 to the run bit while it is 1 empties the queue, aborts the current symbol and forces the output to 0 on the next cycle.
- R11: After reset the output, `irq`, the run bit, all flags and the fill level are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for `bus_addr` |
| carrier_in | input | 1 | Modulation carrier, synchronous to `clk` |
| ir_out | output | 1 | Registered infrared drive |
| irq | output | 1 | Refill request |

## Verification
The hardest states to reach from the ports are a queue that is completely full while a symbol is waiting, and a pending flag that rises only as playback drains the queue. The bench reaches both by stopping playback, filling the queue well past its depth, and reading back the level and flags. It then restarts playback with slow spaces, so the level crosses the threshold at a known time. Carrier-counted marks are started at a known carrier phase so that the number of gated pulses is exact.

// File: rtl/irseq_pkg.sv
package irseq_pkg;
  localparam int PUSH_BIT  = 16;
  localparam int PEND_BIT  = 16;
  localparam int OVF_BIT   = 17;
  localparam int IEN_BIT   = 8;
  localparam int SYM_W     = 13;
  localparam int DUR_W     = 10;

  localparam int OFF_CTRL  = 'h0;
  localparam int OFF_STAT  = 'h4;
  localparam int OFF_FIFO  = 'h8;
  localparam int OFF_IRQ   = 'hC;

  typedef enum logic [1:0] {
    TB_1US     = 2'd0,
    TB_10US    = 2'd1,
    TB_100US   = 2'd2,
    TB_CARRIER = 2'd3
  } tb_e;

  // Layout matches the pushed word bits 12:0
  typedef struct packed {
    logic             mark;
    tb_e              tb;
    logic [DUR_W-1:0] dur;
  } sym_t;
endpackage

// File: rtl/irseq_fifo.sv
module irseq_fifo #(
  parameter int W     = 13,
  parameter int DEPTH = 128
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic                         empty,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign empty   = (level == '0);
  assign full    = (level == LW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/irseq_tick.sv
module irseq_tick import irseq_pkg::*; #(
  parameter int CLK_PER_US = 125
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  tb_e  sel,
  input  logic car_rise,
  output logic tick
);
  localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

  logic       us_tick, t10, t100;
  logic [3:0] d10, d100;

  generate
    if (CLK_PER_US > 1) begin : g_pre
      logic [PW-1:0] pre;
      assign us_tick = (pre == PW'(CLK_PER_US - 1));
      always_ff @(posedge clk) begin
        if (rst || restart) pre <= '0;
        else if (us_tick)   pre <= '0;
        else                pre <= pre + 1'b1;
      end
    end else begin : g_nopre
      assign us_tick = 1'b1;
    end
  endgenerate

  assign t10  = us_tick && (d10 == 4'd9);
  assign t100 = t10 && (d100 == 4'd9);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      d10  <= '0;
      d100 <= '0;
    end else begin
      if (us_tick) d10  <= (d10 == 4'd9)  ? 4'd0 : d10 + 1'b1;
      if (t10)     d100 <= (d100 == 4'd9) ? 4'd0 : d100 + 1'b1;
    end
  end

  always_comb begin
    case (sel)
      TB_1US:   tick = us_tick;
      TB_10US:  tick = t10;
      TB_100US: tick = t100;
      default:  tick = car_rise;
    endcase
  end
endmodule

// File: rtl/irseq_regs.sv
module irseq_regs import irseq_pkg::*; #(
  parameter int DEPTH  = 128,
  parameter int ADDR_W = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_wr,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  input  logic [$clog2(DEPTH+1)-1:0] level,
  input  logic                       busy,
  input  logic                       fifo_full,
  output logic                       en,
  output logic                       flush,
  output logic                       push,
  output sym_t                       push_sym,
  output logic [$clog2(DEPTH)-1:0]   thr,
  output logic                       ien,
  output logic                       pend,
  output logic                       ovf,
  output logic                       irq
);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int TW = $clog2(DEPTH);

  logic wr_ctrl, wr_fifo, wr_irq;
  logic [31:0] rd_next;

  assign wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
  assign wr_fifo  = bus_wr && (bus_addr == ADDR_W'(OFF_FIFO));
  assign wr_irq   = bus_wr && (bus_addr == ADDR_W'(OFF_IRQ));
  assign flush    = wr_ctrl && !bus_wdata[0] && en;
  assign push     = wr_fifo && bus_wdata[PUSH_BIT];
  assign push_sym = sym_t'(bus_wdata[SYM_W-1:0]);
  assign irq      = pend && ien;

  always_comb begin
    rd_next = '0;
    if (bus_addr == ADDR_W'(OFF_CTRL)) begin
      rd_next[0] = en;
    end else if (bus_addr == ADDR_W'(OFF_STAT)) begin
      rd_next[LW-1:0] = level;
      rd_next[8]      = busy;
    end else if (bus_addr == ADDR_W'(OFF_IRQ)) begin
      rd_next[TW-1:0]  = thr;
      rd_next[IEN_BIT] = ien;
      rd_next[PEND_BIT] = pend;
      rd_next[OVF_BIT] = ovf;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en        <= 1'b0;
      thr       <= '0;
      ien       <= 1'b0;
      pend      <= 1'b0;
      ovf       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_rdata <= rd_next;
      if (wr_ctrl) en <= bus_wdata[0];
      if (wr_irq) begin
        thr <= bus_wdata[TW-1:0];
        ien <= bus_wdata[IEN_BIT];
      end
      if (wr_irq && !bus_wdata[PEND_BIT]) pend <= 1'b0;
      else pend <= pend | (ien && (level <= LW'(thr)));
      if (wr_irq && !bus_wdata[OVF_BIT]) ovf <= 1'b0;
      else ovf <= ovf | (push && fifo_full);
    end
  end
endmodule

// File: rtl/irseq_top.sv
module irseq_top import irseq_pkg::*; #(
  parameter int DEPTH      = 128,
  parameter int ADDR_W     = 4,
  parameter int CLK_PER_US = 125
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              carrier_in,
  output logic              ir_out,
  output logic              irq
);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int TW = $clog2(DEPTH);

  logic          en, flush, push, pend, ovf, ien;
  logic [TW-1:0] thr;
  sym_t          push_sym, head, cur;
  logic          fifo_empty, fifo_full, pop;
  logic [LW-1:0] level;
  logic          busy, tick, done, car_q, car_rise;
  logic [DUR_W-1:0] left;

  irseq_regs #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .level(level),
    .busy(busy), .fifo_full(fifo_full), .en(en), .flush(flush),
    .push(push), .push_sym(push_sym), .thr(thr), .ien(ien),
    .pend(pend), .ovf(ovf), .irq(irq)
  );

  irseq_fifo #(.W(SYM_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .flush(flush), .push(push), .din(push_sym),
    .pop(pop), .dout(head), .empty(fifo_empty), .full(fifo_full),
    .level(level)
  );

  assign car_rise = carrier_in && !car_q;
  assign done     = busy && tick && (left == '0);
  assign pop      = en && !flush && !fifo_empty && (!busy || done);

  irseq_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk(clk), .rst(rst), .restart(pop), .sel(cur.tb),
    .car_rise(car_rise), .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      car_q  <= 1'b0;
      ir_out <= 1'b0;
    end else begin
      car_q  <= carrier_in;
      ir_out <= busy && cur.mark && carrier_in && !flush;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      busy <= 1'b0;
      cur  <= '0;
      left <= '0;
    end else if (pop) begin
      busy <= 1'b1;
      cur  <= head;
      left <= head.dur;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy && tick) begin
      left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/irseq_chk.sv
module irseq_chk #(
  parameter int DEPTH  = 128,
  parameter int ADDR_W = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       en,
  input logic                       ir_out,
  input logic                       busy,
  input logic                       mark,
  input logic [$clog2(DEPTH+1)-1:0] level,
  input logic [$clog2(DEPTH)-1:0]   thr,
  input logic                       ien,
  input logic                       pend,
  input logic                       ovf,
  input logic                       bus_wr,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [31:0]                bus_wdata,
  input logic                       pop,
  input logic                       fifo_empty
);
  localparam int LW = $clog2(DEPTH + 1);

  // R2: a space never drives the pin
  a_r2_space_quiet: assert property (@(posedge clk) disable iff (rst)
    (busy && !mark) |=> !ir_out);

  // R5: a pop only takes an existing entry
  a_r5_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
    pop |-> !fifo_empty);

  // R7: the level is bounded by the depth
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH));

  // R7: overflow flag is sticky until cleared by software
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf && !(bus_wr && bus_addr == ADDR_W'('hC) && !bus_wdata[17])) |=> ovf);

  // R8: pending only rises with a cause
  a_r8_pend_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(pend) |-> $past(ien && (level <= LW'(thr))));

  // R10: a stopped player keeps the pin low
  a_r10_off_quiet: assert property (@(posedge clk) disable iff (rst)
    !en |-> !ir_out);
endmodule

bind irseq_top irseq_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .ir_out(ir_out), .busy(busy),
  .mark(cur.mark), .level(level), .thr(thr), .ien(ien), .pend(pend),
  .ovf(ovf), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .pop(pop), .fifo_empty(fifo_empty)
);

// File: tb/irseq_top_test.sv
module irseq_top_test;
  localparam int CPU = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        carrier_in;
  logic        ir_out, irq;
  logic        car_mode = 1'b0;
  logic        car_force = 1'b1;
  logic [31:0] cyc = '0;
  int total = 0;
  int bad = 0;
  logic finished = 1'b0;

  always #4 clk = ~clk;
  always @(negedge clk) cyc <= cyc + 1;
  assign carrier_in = car_mode ? cyc[2] : car_force;

  irseq_top #(.DEPTH(128), .ADDR_W(4), .CLK_PER_US(CPU)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .carrier_in(carrier_in),
    .ir_out(ir_out), .irq(irq)
  );

  // {unit code, duration-1, expected high cycles} with CPU=2
  localparam logic [31:0] VEC [0:5] = '{
    {2'd0, 10'd0,    20'd2},
    {2'd0, 10'd4,    20'd10},
    {2'd1, 10'd1,    20'd40},
    {2'd2, 10'd0,    20'd200},
    {2'd0, 10'd1023, 20'd2048},
    {2'd1, 10'd2,    20'd60}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  function automatic logic [31:0] sym(input bit mk, input logic [1:0] tb,
                                      input logic [9:0] dur);
    return 32'h0001_0000 | (32'(mk) << 12) | (32'(tb) << 10) | 32'(dur);
  endfunction

  task automatic wait_high(output int w);
    int guard = 0;
    w = 0;
    while (!ir_out && guard < 5000) begin @(negedge clk); guard++; end
    while (ir_out && w < 5000) begin @(negedge clk); w++; end
  endtask

  task automatic count_low(output int w);
    w = 0;
    while (!ir_out && w < 5000) begin @(negedge clk); w++; end
  endtask

  initial begin
    logic [31:0] d;
    int w1, w2, w3, rises, highs;
    logic prev;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 ir_out", int'(ir_out), 0);
    chk("R11 irq", int'(irq), 0);
    rd(4'h4, d); chk("R11 status", int'(d), 0);
    rd(4'hC, d); chk("R11 irqreg", int'(d), 0);
    rd(4'h0, d); chk("R11 ctrl", int'(d), 0);

    wr(4'h0, 32'h1);
    // R3 / R6: table of unit codes and durations, each from an empty queue
    foreach (VEC[i]) begin
      wr(4'h8, sym(1'b1, VEC[i][31:30], VEC[i][29:20]));
      wait_high(w1);
      chk($sformatf("R3 vec%0d width", i), w1, int'(VEC[i][19:0]));
    end
    rd(4'h4, d); chk("R6 idle status", int'(d), 0);

    // R5: back-to-back mark, space, mark
    wr(4'h0, 32'h0);
    wr(4'h8, sym(1'b1, 2'd0, 10'd4));
    wr(4'h8, sym(1'b0, 2'd0, 10'd9));
    wr(4'h8, sym(1'b1, 2'd0, 10'd2));
    wr(4'h0, 32'h1);
    wait_high(w1);
    count_low(w2);
    wait_high(w3);
    chk("R5 first mark", w1, 10);
    chk("R5 space gap", w2, 20);
    chk("R5 second mark", w3, 6);
    repeat (5) @(negedge clk);
    chk("R6 output low when empty", int'(ir_out), 0);
    rd(4'h4, d); chk("R6 not busy", int'(d), 0);

    // R4: carrier-period unit, started in a low carrier phase
    car_mode = 1'b1;
    do begin @(negedge clk); end while (cyc[2:0] != 3'd7);
    bus_wr = 1'b1; bus_addr = 4'h8; bus_wdata = sym(1'b1, 2'd3, 10'd2);
    @(posedge clk); @(negedge clk); bus_wr = 1'b0;
    rises = 0; prev = 1'b0;
    for (int k = 0; k < 60; k++) begin
      if (ir_out && !prev) rises++;
      prev = ir_out;
      @(negedge clk);
    end
    chk("R4 carrier pulses", rises, 3);

    // R2: space with the carrier running stays low
    wr(4'h8, sym(1'b0, 2'd0, 10'd49));
    highs = 0;
    for (int k = 0; k < 110; k++) begin
      if (ir_out) highs++;
      @(negedge clk);
    end
    chk("R2 space quiet", highs, 0);
    car_mode = 1'b0;

    // R1 / R7 / R10: stop, push, overflow, flush
    wr(4'h0, 32'h0);
    wr(4'h8, 32'h0000_1005);
    rd(4'h4, d); chk("R1 no push without bit16", int'(d), 0);
    for (int k = 0; k < 130; k++) wr(4'h8, sym(1'b0, 2'd2, 10'd10));
    rd(4'h4, d); chk("R7 R10 level held while stopped", int'(d), 128);
    rd(4'hC, d); chk("R7 overflow flag", int'(d[17]), 1);
    wr(4'hC, 32'h0);
    rd(4'hC, d); chk("R7 overflow cleared", int'(d[17]), 0);
    wr(4'h0, 32'h1);
    @(negedge clk);
    rd(4'h4, d); chk("R10 playing after run", int'(d), 256 + 127);
    wr(4'h0, 32'h0);
    rd(4'h4, d); chk("R10 flushed", int'(d), 0);
    chk("R10 output low", int'(ir_out), 0);

    // R8 / R9: threshold interrupt
    wr(4'hC, 32'h0000_0002);
    repeat (3) @(negedge clk);
    chk("R9 no irq when disabled", int'(irq), 0);
    rd(4'hC, d); chk("R8 no pending when disabled", int'(d[16]), 0);
    for (int k = 0; k < 4; k++) wr(4'h8, sym(1'b0, 2'd0, 10'd19));
    wr(4'hC, 32'h0000_0102);
    repeat (3) @(negedge clk);
    chk("R8 above threshold", int'(irq), 0);
    wr(4'h0, 32'h1);
    repeat (60) @(negedge clk);
    chk("R8 R9 irq at threshold", int'(irq), 1);
    rd(4'hC, d); chk("R8 pending read", int'(d[16]), 1);
    wr(4'hC, 32'h0001_0102);
    rd(4'hC, d); chk("R8 write one keeps", int'(d[16]), 1);
    wr(4'hC, 32'h0000_0002);
    @(negedge clk);
    chk("R9 irq off", int'(irq), 0);
    rd(4'hC, d); chk("R8 cleared", int'(d[16]), 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule